// File: doc/BRIEF.md
# Power Test Override Sequencer

This block sits between a functional power controller and one switchable power domain. In normal operation it passes the controller's four power-management requests (retention save, retention restore, isolation enable, power-switch off) straight through. When test mode is raised, the controller's requests no longer reach the domain. The block drives those four controls itself and runs a fixed state-retention test.

The test runs as follows. A start pulse arms the sequencer, which then waits for the scan load to finish. After that, each step pulse moves it one stage forward. The stages are: save the retained state, isolate the domain, switch its power off, switch it back on, remove isolation, and restore the retained state. The sequence ends by allowing the scan unload. Between steps the domain's power and isolation state is held unchanged, so capture can take place while the domain is truly off. Busy and phase outputs let the test controller follow progress.

Top module: `pwr_test_seq`

## Requirements
- R1: While `test_mode` is 1, the four control outputs are driven only by the sequencer. The `func_*` request inputs have no effect on them, and in phases 0 and 1 all four outputs are 0.
- R2: While `test_mode` is 0, each control output equals its matching `func_*` input in the same cycle.
- R3: A `start` pulse sampled in phase 0 with `test_mode` 1 moves the block to phase 1 with `busy` 1. A `start` sampled while `busy` is 1, or while `test_mode` is 0, changes nothing.
- R4: The phase advances only on a sampled `step`. In phase 1 a `step` is taken only when `shift_in_done` is 1. In phase 7 a `step` is taken only when `shift_out_done` is 1, and it returns the block to phase 0.
- R5: Phase codes on `phase` follow a fixed order: 0 idle, 1 loading, 2 saved, 3 isolated, 4 powered off, 5 powered on, 6 de-isolated, 7 restored (unload allowed). `busy` is 1 exactly when `phase` is not 0.
- R6: `ret_save` is a one-cycle pulse in the first cycle of phase 2. `ret_restore` is a one-cycle pulse in the first cycle of phase 7.
- R7: In test mode, `iso_en` is 1 in phases 3, 4 and 5 and 0 otherwise. `pwr_off` is 1 only in phase 4, so isolation is on before power-off and stays on until after power-on.
- R8: With no step taken, the test-mode `iso_en` and `pwr_off` values do not change from one cycle to the next.
- R9: Dropping `test_mode` during a sequence returns the block to phase 0, with the test-side controls cleared.
- R10: Reset gives phase 0 and `busy` 0. In test mode it also gives the domain powered on, isolation off and retention inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| test_mode | input | 1 | Selects sequencer control of the domain |
| start | input | 1 | Starts a retention-test sequence |
| step | input | 1 | Advances the sequence one stage |
| shift_in_done | input | 1 | Scan load is complete |
| shift_out_done | input | 1 | Scan unload is complete |
| func_ret_save | input | 1 | Functional retention save request |
| func_ret_restore | input | 1 | Functional retention restore request |
| func_iso_en | input | 1 | Functional isolation request |
| func_pwr_off | input | 1 | Functional power-switch off request |
| ret_save | output | 1 | Retention save control to the domain |
| ret_restore | output | 1 | Retention restore control to the domain |
| iso_en | output | 1 | Isolation enable to the domain boundary |
| pwr_off | output | 1 | Power switch off control |
| busy | output | 1 | Sequence in progress |
| phase | output | 3 | Current sequence phase code |

## Verification
The pass-through is tried with two different functional request patterns while test mode is low. The same all-ones pattern is then applied with test mode high, which separates correct override from leakage of the functional requests. The full sequence is walked with idle cycles between steps. Those idle cycles separate holding from drifting, and they show that the save and restore pulses last exactly one cycle. Steps are also offered without the shift handshakes and starts are issued mid-sequence, which tells gated advancement apart from free-running advancement. Directed runs then drop test mode and assert reset in the middle of a sequence, which tells a clean return to idle apart from stale held state.

// File: rtl/pts_pkg.sv
package pts_pkg;
  localparam int PHASE_W = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE     = 3'd0,
    PH_LOAD     = 3'd1,
    PH_SAVED    = 3'd2,
    PH_ISO      = 3'd3,
    PH_OFF      = 3'd4,
    PH_ON       = 3'd5,
    PH_DEISO    = 3'd6,
    PH_RESTORED = 3'd7
  } phase_e;

  localparam int NUM_CTRL = 4;
  localparam int CI_SAVE  = 3;
  localparam int CI_REST  = 2;
  localparam int CI_ISO   = 1;
  localparam int CI_OFF   = 0;
endpackage

// File: rtl/pts_rst_sync.sv
module pts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[LAST-1:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[LAST];
endmodule

// File: rtl/pts_seq_fsm.sv
module pts_seq_fsm
  import pts_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               test_mode,
  input  logic               start,
  input  logic               step,
  input  logic               shift_in_done,
  input  logic               shift_out_done,
  output logic [NUM_CTRL-1:0] tctrl,
  output logic               busy,
  output logic [PHASE_W-1:0] phase
);
  phase_e phase_q, phase_d;
  logic   save_q, save_d;
  logic   rest_q, rest_d;
  logic   iso_q, iso_d;
  logic   off_q, off_d;

  // next-state decode
  always_comb begin
    phase_d = phase_q;
    if (!test_mode) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE:     if (start) phase_d = PH_LOAD;
        PH_LOAD:     if (step && shift_in_done) phase_d = PH_SAVED;
        PH_SAVED:    if (step) phase_d = PH_ISO;
        PH_ISO:      if (step) phase_d = PH_OFF;
        PH_OFF:      if (step) phase_d = PH_ON;
        PH_ON:       if (step) phase_d = PH_DEISO;
        PH_DEISO:    if (step) phase_d = PH_RESTORED;
        PH_RESTORED: if (step && shift_out_done) phase_d = PH_IDLE;
        default:     phase_d = PH_IDLE;
      endcase
    end
    save_d = (phase_d == PH_SAVED) && (phase_q != PH_SAVED);
    rest_d = (phase_d == PH_RESTORED) && (phase_q != PH_RESTORED);
    iso_d  = (phase_d == PH_ISO) || (phase_d == PH_OFF) || (phase_d == PH_ON);
    off_d  = (phase_d == PH_OFF);
  end

  // state and registered test-side controls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      save_q  <= 1'b0;
      rest_q  <= 1'b0;
      iso_q   <= 1'b0;
      off_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      save_q  <= save_d;
      rest_q  <= rest_d;
      iso_q   <= iso_d;
      off_q   <= off_d;
    end
  end

  always_comb begin
    tctrl          = '0;
    tctrl[CI_SAVE] = save_q;
    tctrl[CI_REST] = rest_q;
    tctrl[CI_ISO]  = iso_q;
    tctrl[CI_OFF]  = off_q;
  end

  assign busy  = (phase_q != PH_IDLE);
  assign phase = phase_q;

  // R7
  off_needs_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |-> iso_q);

  // R6
  save_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_q |=> !save_q);

  // R6
  restore_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rest_q |-> (phase_q == PH_RESTORED));

  // R8
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !step) |=> ($stable(iso_q) && $stable(off_q)));

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && test_mode && start && !step) |=> $stable(phase_q));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> (phase_q == PH_IDLE) && !iso_q && !off_q);
endmodule

// File: rtl/pts_ovr_mux.sv
module pts_ovr_mux #(
  parameter int WIDTH = 4
) (
  input  logic             sel_test,
  input  logic [WIDTH-1:0] func_req,
  input  logic [WIDTH-1:0] test_req,
  output logic [WIDTH-1:0] ctrl_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign ctrl_out[g] = sel_test ? test_req[g] : func_req[g];
  end
endmodule

// File: rtl/pwr_test_seq.sv
module pwr_test_seq
  import pts_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               test_mode,
  input  logic               start,
  input  logic               step,
  input  logic               shift_in_done,
  input  logic               shift_out_done,
  input  logic               func_ret_save,
  input  logic               func_ret_restore,
  input  logic               func_iso_en,
  input  logic               func_pwr_off,
  output logic               ret_save,
  output logic               ret_restore,
  output logic               iso_en,
  output logic               pwr_off,
  output logic               busy,
  output logic [PHASE_W-1:0] phase
);
  logic                rst_sync_n;
  logic [NUM_CTRL-1:0] func_vec;
  logic [NUM_CTRL-1:0] test_vec;
  logic [NUM_CTRL-1:0] out_vec;

  pts_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pts_seq_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .test_mode      (test_mode),
    .start          (start),
    .step           (step),
    .shift_in_done  (shift_in_done),
    .shift_out_done (shift_out_done),
    .tctrl          (test_vec),
    .busy           (busy),
    .phase          (phase)
  );

  always_comb begin
    func_vec          = '0;
    func_vec[CI_SAVE] = func_ret_save;
    func_vec[CI_REST] = func_ret_restore;
    func_vec[CI_ISO]  = func_iso_en;
    func_vec[CI_OFF]  = func_pwr_off;
  end

  pts_ovr_mux #(.WIDTH(NUM_CTRL)) u_mux (
    .sel_test (test_mode),
    .func_req (func_vec),
    .test_req (test_vec),
    .ctrl_out (out_vec)
  );

  assign ret_save    = out_vec[CI_SAVE];
  assign ret_restore = out_vec[CI_REST];
  assign iso_en      = out_vec[CI_ISO];
  assign pwr_off     = out_vec[CI_OFF];

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (test_mode && (phase == PH_IDLE)) |-> !(ret_save || ret_restore || iso_en || pwr_off));

  // R7
  top_off_iso_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (test_mode && pwr_off) |-> (iso_en && phase == PH_OFF));
endmodule

// File: tb/tb_pwr_test_seq.sv
module tb_pwr_test_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic test_mode, start, step, shift_in_done, shift_out_done;
  logic func_ret_save, func_ret_restore, func_iso_en, func_pwr_off;
  logic ret_save, ret_restore, iso_en, pwr_off, busy;
  logic [2:0] phase;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_test_seq dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start), .step(step),
    .shift_in_done(shift_in_done), .shift_out_done(shift_out_done),
    .func_ret_save(func_ret_save), .func_ret_restore(func_ret_restore),
    .func_iso_en(func_iso_en), .func_pwr_off(func_pwr_off),
    .ret_save(ret_save), .ret_restore(ret_restore), .iso_en(iso_en),
    .pwr_off(pwr_off), .busy(busy), .phase(phase)
  );

  // stim: {test_mode,start,step,shift_in_done,shift_out_done,f_save,f_rest,f_iso,f_off}
  // exp : {phase[2:0],busy,save,restore,iso,off}
  localparam int NV = 19;
  localparam logic [8:0] STIM [NV] = '{
    9'b0_0000_1111, 9'b0_0000_0101, 9'b0_1000_0000, 9'b1_0000_1111,
    9'b1_1000_0000, 9'b1_0100_0000, 9'b1_0110_0000, 9'b1_0000_1111,
    9'b1_1000_0000, 9'b1_0100_0000, 9'b1_0000_0000, 9'b1_0100_0000,
    9'b1_0000_1111, 9'b1_0100_0000, 9'b1_0100_0000, 9'b1_0100_0000,
    9'b1_0000_0000, 9'b1_0100_0000, 9'b1_0101_0000
  };
  localparam logic [7:0] EXPV [NV] = '{
    8'b000_0_1111, 8'b000_0_0101, 8'b000_0_0000, 8'b000_0_0000,
    8'b001_1_0000, 8'b001_1_0000, 8'b010_1_1000, 8'b010_1_0000,
    8'b010_1_0000, 8'b011_1_0010, 8'b011_1_0010, 8'b100_1_0011,
    8'b100_1_0011, 8'b101_1_0010, 8'b110_1_0000, 8'b111_1_0100,
    8'b111_1_0000, 8'b111_1_0000, 8'b000_0_0000
  };
  // requirement names per vector
  localparam string RQ [NV] = '{
    "R2", "R2", "R3", "R1", "R3", "R4", "R6", "R6", "R3", "R7",
    "R8", "R7", "R1", "R7", "R5", "R6", "R6", "R4", "R4"
  };

  function automatic logic [7:0] obs();
    return {phase, busy, ret_save, ret_restore, iso_en, pwr_off};
  endfunction

  task automatic check(input string req, input logic [7:0] exp_v);
    checks++;
    if (obs() !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, obs(), exp_v);
    end
  endtask

  task automatic apply(input logic [8:0] s);
    {test_mode, start, step, shift_in_done, shift_out_done,
     func_ret_save, func_ret_restore, func_iso_en, func_pwr_off} = s;
  endtask

  task automatic cyc(input logic [8:0] s);
    apply(s);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    apply(9'b1_0000_1111);
    repeat (3) @(negedge clk);
    // R10: reset state, test mode high with all functional requests set
    check("R10", 8'b000_0_0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", 8'b000_0_0000);

    for (int i = 0; i < NV; i++) begin
      cyc(STIM[i]);
      check(RQ[i], EXPV[i]);
    end

    // R9: abort from the isolated phase
    cyc(9'b1_1000_0000);
    cyc(9'b1_0110_0000);
    cyc(9'b1_0100_0000);
    check("R7", 8'b011_1_0010);
    apply(9'b0_0000_1010);
    #1;
    check("R2", 8'b011_1_1010);
    @(negedge clk);
    check("R9", 8'b000_0_1010);
    cyc(9'b1_0000_0000);
    check("R9", 8'b000_0_0000);

    // R10: reset while powered off
    cyc(9'b1_1000_0000);
    cyc(9'b1_0110_0000);
    cyc(9'b1_0100_0000);
    cyc(9'b1_0100_0000);
    check("R7", 8'b100_1_0011);
    rst_n = 1'b0;
    #1;
    check("R10", 8'b000_0_0000);
    apply(9'b1_0000_0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", 8'b000_0_0000);

    // R3: start and step together in idle starts only
    cyc(9'b1_1110_0000);
    check("R3", 8'b001_1_0000);
    cyc(9'b0_0000_0000);
    check("R9", 8'b000_0_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule